// File: doc/BRIEF.md
# Pad Controller with Event Detection and Banked Interrupts

This block owns a row of general-purpose pads, up to roughly eighty, and exposes them to a host through a plain 32-bit register port. Every pad has a configuration word of its own. That word holds the value the pad drives and returns the synchronised level seen on the pad. It also holds a control that inverts the received level, and a two-bit field that selects how events are detected.

Each received level passes through a synchroniser and the optional inversion. It is then watched for a level, a rising edge or any change. A detected event sets a sticky bit in a 32-bit status word that covers 32 pads. A matching enable word per group of 32 pads decides which pending events reach the single interrupt line. The host reads a status word and writes the same value back. That write clears exactly the events it saw, and events that arrive in the meantime stay pending.

Top module: `gpio_event_ctrl`

## Requirements
- R1: While reset is high, and after it, all stored pad fields, all enable bits and all status bits are zero, irq is low and every pad_out bit is low.
- R2: Bit 0 of the word at address 0x500 + 8*n is the drive value of pad n. It can be written and read back, and it appears on pad_out[n].
- R3: Bit 1 of a pad word returns pad_in[n] after a two-flop synchroniser. Writes to bit 1 have no effect.
- R4: Bit 23 of a pad word inverts the synchronised level before event detection, so a low input counts as active.
- R5: When bits 26:25 of a pad word hold 00 or 10 (level mode), the pad's status bit is set on every cycle the post-inversion level is high. The bit therefore reappears after a clear while the level persists.
- R6: When bits 26:25 hold 01, a status bit is set on a rising edge of the post-inversion level. When they hold 11, it is set on both rising and falling edges.
- R7: Status word b sits at 0x100 + 4*b and holds pad 32*b + i in bit i. Writing 1 to a bit clears it, and bits written 0 keep their value.
- R8: An event and a clear of the same status bit in the same cycle leave the bit set.
- R9: Enable word b sits at 0x110 + 4*b with the same bit layout. Status bits latch whatever the enables hold. irq is a register that follows the OR of status AND enable one cycle later.
- R10: Bits of the last status and enable words that have no pad read as zero. Addresses that map to nothing read as zero.
- R11: host_rvalid is high, and host_rdata holds the addressed word, in the cycle after a cycle with host_rd high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for one cycle |
| host_rd | input | 1 | Read strobe for one cycle |
| host_addr | input | ADDR_W | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| pad_in | input | NUM_PADS | Raw levels received from the pads |
| pad_out | output | NUM_PADS | Drive values toward the pads |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A detected event and a host clear of the same status bit can land in one clock cycle. The level-mode case is provoked by holding an input active while its bit is cleared; the bit must read back set. The edge-mode case is provoked by timing a pad transition so that the detected edge meets the clear write on the same edge; this is counted through the two synchroniser stages and the detector. The bit must survive that write and then drop on a second clear that has no event.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned STS_BASE   = 32'h100;
  localparam int unsigned EN_BASE    = 32'h110;
  localparam int unsigned PAD_BASE   = 32'h500;
  localparam int unsigned PAD_STRIDE = 8;
  localparam int unsigned BANK_STEP  = 4;

  // bit positions inside a pad word (host software decodes these)
  localparam int unsigned DRV_BIT = 0;
  localparam int unsigned LVL_BIT = 1;
  localparam int unsigned INV_BIT = 23;
  localparam int unsigned MODE_LO = 25;

  typedef enum logic [1:0] {
    EV_LEVEL     = 2'b00,
    EV_RISE      = 2'b01,
    EV_LEVEL_ALT = 2'b10,
    EV_BOTH      = 2'b11
  } ev_mode_e;

  typedef struct packed {
    ev_mode_e mode;
    logic     inv;
    logic     drive;
  } pad_cfg_t;

  function automatic logic [REG_W-1:0] pack_pad(pad_cfg_t c, logic lvl);
    logic [REG_W-1:0] w;
    w = '0;
    w[DRV_BIT]        = c.drive;
    w[LVL_BIT]        = lvl;
    w[INV_BIT]        = c.inv;
    w[MODE_LO +: 2]   = c.mode;
    return w;
  endfunction

endpackage

// File: rtl/gpio_pad_event.sv
module gpio_pad_event
  import gpio_event_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pad_i,
  input  logic     cfg_inv,
  input  ev_mode_e cfg_mode,
  output logic     lvl_sync_o,
  output logic     evt_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
      prev_q <= lvl;
    end
  end

  assign lvl_sync_o = sync_q[SYNC_STAGES-1];
  assign lvl        = lvl_sync_o ^ cfg_inv;

  always_comb begin
    unique case (cfg_mode)
      EV_RISE: evt_o = lvl & ~prev_q;
      EV_BOTH: evt_o = lvl ^ prev_q;
      default: evt_o = lvl;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_event_pkg::*;
#(
  parameter int LIVE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] evt_i,
  input  logic [BANK_W-1:0] clr_i,
  input  logic              en_we,
  input  logic [BANK_W-1:0] en_wdata,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] enable_o
);

  localparam logic [BANK_W-1:0] MASK = {BANK_W{1'b1}} >> (BANK_W - LIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      status_o <= ((status_o & ~clr_i) | evt_i) & MASK;
      if (en_we) enable_o <= en_wdata & MASK;
    end
  end

endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
  import gpio_event_pkg::*;
#(
  parameter int NUM_PADS    = 78,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [REG_W-1:0]    host_wdata,
  output logic [REG_W-1:0]    host_rdata,
  output logic                host_rvalid,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic                irq
);

  localparam int NBANKS = (NUM_PADS + BANK_W - 1) / BANK_W;
  localparam int FLAT_W = NBANKS * BANK_W;

  pad_cfg_t            cfg_q [NUM_PADS];
  logic [NUM_PADS-1:0] pad_hit;
  logic [NUM_PADS-1:0] lvl_sync;
  logic [NUM_PADS-1:0] evt_vec;
  logic [FLAT_W-1:0]   evt_all;
  logic [FLAT_W-1:0]   clr_all;
  logic [FLAT_W-1:0]   status_all;
  logic [FLAT_W-1:0]   enable_all;
  logic [NBANKS-1:0]   sts_hit;
  logic [NBANKS-1:0]   en_hit;
  logic [REG_W-1:0]    rd_mux;

  generate
    for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
      assign pad_hit[n] = (host_addr == ADDR_W'(PAD_BASE + PAD_STRIDE * n));

      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_q[n] <= '0;
        end else if (host_wr && pad_hit[n]) begin
          cfg_q[n].drive <= host_wdata[DRV_BIT];
          cfg_q[n].inv   <= host_wdata[INV_BIT];
          cfg_q[n].mode  <= ev_mode_e'(host_wdata[MODE_LO +: 2]);
        end
      end

      assign pad_out[n] = cfg_q[n].drive;

      gpio_pad_event #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
        .clk        (clk),
        .rst        (rst),
        .pad_i      (pad_in[n]),
        .cfg_inv    (cfg_q[n].inv),
        .cfg_mode   (cfg_q[n].mode),
        .lvl_sync_o (lvl_sync[n]),
        .evt_o      (evt_vec[n])
      );
    end
  endgenerate

  assign evt_all = FLAT_W'(evt_vec);

  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      localparam int LIVE = (NUM_PADS - b * BANK_W > BANK_W) ? BANK_W : NUM_PADS - b * BANK_W;

      assign sts_hit[b] = (host_addr == ADDR_W'(STS_BASE + BANK_STEP * b));
      assign en_hit[b]  = (host_addr == ADDR_W'(EN_BASE + BANK_STEP * b));
      assign clr_all[b*BANK_W +: BANK_W] = (host_wr && sts_hit[b]) ? host_wdata : '0;

      gpio_irq_bank #(.LIVE(LIVE)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_all[b*BANK_W +: BANK_W]),
        .clr_i    (clr_all[b*BANK_W +: BANK_W]),
        .en_we    (host_wr && en_hit[b]),
        .en_wdata (host_wdata),
        .status_o (status_all[b*BANK_W +: BANK_W]),
        .enable_o (enable_all[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (sts_hit[b]) rd_mux = rd_mux | status_all[b*BANK_W +: BANK_W];
      if (en_hit[b])  rd_mux = rd_mux | enable_all[b*BANK_W +: BANK_W];
    end
    for (int n = 0; n < NUM_PADS; n++) begin
      if (pad_hit[n]) rd_mux = rd_mux | pack_pad(cfg_q[n], lvl_sync[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      irq         <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
      irq <= |(status_all & enable_all);
    end
  end

endmodule

// File: rtl/gpio_event_ctrl_chk.sv
module gpio_event_ctrl_chk #(
  parameter int NUM_PADS = 78,
  parameter int FLAT_W   = 96
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rd,
  input logic              host_rvalid,
  input logic              irq,
  input logic [FLAT_W-1:0] evt_all,
  input logic [FLAT_W-1:0] clr_all,
  input logic [FLAT_W-1:0] status_all,
  input logic [FLAT_W-1:0] enable_all
);

  localparam logic [FLAT_W-1:0] LIVE_MASK = {FLAT_W{1'b1}} >> (FLAT_W - NUM_PADS);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (status_all == '0 && enable_all == '0 && !irq));

  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);

  // R8
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_all) |=> ((status_all & $past(evt_all)) == $past(evt_all)));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_all & $past(status_all & ~clr_all)) == $past(status_all & ~clr_all)));

  // R10
  unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_all | enable_all) & ~LIVE_MASK) == '0);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_all == '0) |=> !irq);

endmodule

bind gpio_event_ctrl gpio_event_ctrl_chk #(.NUM_PADS(NUM_PADS), .FLAT_W(FLAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_rd     (host_rd),
  .host_rvalid (host_rvalid),
  .irq         (irq),
  .evt_all     (evt_all),
  .clr_all     (clr_all),
  .status_all  (status_all),
  .enable_all  (enable_all)
);

// File: tb/gpio_event_ctrl_test.sv
module gpio_event_ctrl_test;

  localparam int NP = 40;
  localparam int AW = 12;
  localparam logic [AW-1:0] STS0 = 12'h100, STS1 = 12'h104;
  localparam logic [AW-1:0] EN0  = 12'h110, EN1  = 12'h114;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          host_rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic          irq;

  int checks = 0;
  int errors = 0;

  gpio_event_ctrl #(.NUM_PADS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] pad_addr(int p);
    return AW'(12'h500 + 8 * p);
  endfunction

  function automatic logic [AW-1:0] sts_addr(int p);
    return (p < 32) ? STS0 : STS1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] drv_exp;
    logic [NP-1:0] in_pat;

    waitc(4);
    // R1: outputs while reset is still high
    chk("R1 irq in reset", irq, 0);
    chk("R1 pad_out in reset", pad_out, 0);
    rst = 1'b0;

    // R1: registers after reset
    rd(STS0, d); chk("R1 sts0", d, 0);
    rd(STS1, d); chk("R1 sts1", d, 0);
    rd(EN0, d);  chk("R1 en0", d, 0);
    rd(EN1, d);  chk("R1 en1", d, 0);
    rd(pad_addr(0), d);  chk("R1 pad0 word", d, 0);
    rd(pad_addr(39), d); chk("R1 pad39 word", d, 0);

    // R11: valid one cycle after strobe, low otherwise
    @(negedge clk); host_rd = 1'b1; host_addr = EN0;
    chk("R11 rvalid not early", host_rvalid, 0);
    @(negedge clk); host_rd = 1'b0;
    chk("R11 rvalid after read", host_rvalid, 1);
    @(negedge clk);
    chk("R11 rvalid drops", host_rvalid, 0);

    // R2: drive bit sweep over all pads
    drv_exp = '0;
    for (int p = 0; p < NP; p++) begin
      drv_exp[p] = (p % 3 == 0);
      wr(pad_addr(p), {31'd0, drv_exp[p]});
    end
    chk("R2 pad_out pattern", pad_out, drv_exp);
    for (int p = 0; p < NP; p++) begin
      rd(pad_addr(p), d);
      chk("R2 drive readback", d, {31'd0, drv_exp[p]});
    end
    for (int p = 0; p < NP; p++) wr(pad_addr(p), 32'd0);
    chk("R2 pad_out cleared", pad_out, 0);

    // R3: synchronised input level in bit 1, writes ignored
    in_pat = 40'hA5_3C96_0F1E;
    pad_in = in_pat;
    waitc(3);
    for (int p = 0; p < NP; p++) begin
      rd(pad_addr(p), d);
      chk("R3 input level bit", d, {30'd0, in_pat[p], 1'b0});
    end
    wr(pad_addr(0), 32'h2);
    rd(pad_addr(0), d);
    chk("R3 write to level bit ignored", d, 0);
    pad_in = '0;
    waitc(4);
    wr(STS0, 32'hFFFF_FFFF); wr(STS1, 32'hFFFF_FFFF);
    rd(STS0, d); chk("R7 clear after input sweep", d, 0);

    // R4 R5 R6: sweep over pad, mode, inversion and transition
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int iv = 0; iv < 2; iv++) begin
          for (int tr = 0; tr < 4; tr++) begin
            logic f, t, plf, plt, e;
            f = tr[1]; t = tr[0];
            plf = f ^ iv[0]; plt = t ^ iv[0];
            case (m)
              1:       e = ~plf & plt;
              3:       e = plf ^ plt;
              default: e = plf | plt;
            endcase
            pad_in[p] = f;
            wr(pad_addr(p), (32'(m) << 25) | (32'(iv) << 23));
            waitc(3);
            wr(STS0, 32'hFFFF_FFFF); wr(STS1, 32'hFFFF_FFFF);
            pad_in[p] = t;
            waitc(4);
            rd(sts_addr(p), d);
            chk($sformatf("R4 R5 R6 pad %0d mode %0d inv %0d from %0d to %0d", p, m, iv, f, t),
                d, {31'd0, e} << (p % 32));
          end
        end
      end
      pad_in[p] = 1'b0;
      wr(pad_addr(p), 32'd0);
    end
    waitc(4);
    wr(STS0, 32'hFFFF_FFFF); wr(STS1, 32'hFFFF_FFFF);

    // R5: level persists through a clear
    pad_in[12] = 1'b1;
    waitc(4);
    wr(STS0, 32'h1 << 12);
    rd(STS0, d); chk("R5 R8 level reappears after clear", d, 32'h1 << 12);
    pad_in[12] = 1'b0;
    waitc(4);
    wr(STS0, 32'h1 << 12);
    rd(STS0, d); chk("R5 level gone then cleared", d, 0);

    // R7: write-one-to-clear touches only written bits
    pad_in[3] = 1'b1; pad_in[5] = 1'b1;
    waitc(4);
    pad_in[3] = 1'b0; pad_in[5] = 1'b0;
    waitc(4);
    wr(STS0, 32'h1 << 3);
    rd(STS0, d); chk("R7 partial clear", d, 32'h1 << 5);
    wr(STS0, d);
    rd(STS0, d); chk("R7 write back read value", d, 0);

    // R8: edge event lands on the same edge as its clear
    wr(pad_addr(7), 32'h1 << 25);
    waitc(3);
    wr(STS0, 32'hFFFF_FFFF);
    pad_in[7] = 1'b1;
    @(negedge clk);
    wr(STS0, 32'h1 << 7);
    rd(STS0, d); chk("R8 edge event beats clear", d, 32'h1 << 7);
    wr(STS0, 32'h1 << 7);
    rd(STS0, d); chk("R8 clear without event", d, 0);
    pad_in[7] = 1'b0;
    wr(pad_addr(7), 32'd0);

    // R9: status latches with enables off, irq follows enable
    pad_in[9] = 1'b1;
    waitc(4);
    pad_in[9] = 1'b0;
    waitc(4);
    chk("R9 irq low with enables off", irq, 0);
    rd(STS0, d); chk("R9 status latched while disabled", d, 32'h1 << 9);
    wr(EN1, 32'h1 << 1);
    waitc(2);
    chk("R9 irq low for other enabled pad", irq, 0);
    wr(EN0, 32'h1 << 9);
    waitc(1);
    chk("R9 irq high when enabled", irq, 1);
    wr(STS0, 32'h1 << 9);
    waitc(1);
    chk("R9 irq low after clear", irq, 0);
    wr(EN0, 32'd0); wr(EN1, 32'd0);

    // R10: unused bits and unmapped addresses
    wr(EN1, 32'hFFFF_FFFF);
    rd(EN1, d); chk("R10 enable unused bits", d, 32'h0000_00FF);
    wr(EN1, 32'd0);
    pad_in[NP-1:32] = '1;
    waitc(4);
    pad_in[NP-1:32] = '0;
    waitc(4);
    rd(STS1, d); chk("R10 status unused bits", d, 32'h0000_00FF);
    wr(STS1, 32'hFFFF_FFFF);
    rd(12'h200, d); chk("R10 unmapped address", d, 0);
    wr(pad_addr(NP), 32'h1);
    rd(pad_addr(NP), d); chk("R10 pad beyond count", d, 0);
    chk("R10 no drive from pad beyond count", pad_out, 0);

    summary();
    $finish;
  end

endmodule